// File: doc/BRIEF.md
# Encoder Counter Capture Bank

This block sits beside a position-encoder front end and freezes its four running counters (revolution index, position within a revolution, speed measurement, free-running timer) into holding registers, so that software or a neighbouring engine always sees a set of four values taken at one and the same clock edge. A registered live view follows the counter inputs and can hold any of the first three counters while a pause input is high.

Three capture banks are loaded from that live view, each by its own trigger. The read bank is loaded by a software read command or by any qualified event. Two snapshot banks are each loaded by the rising edge of their own strobe, but only while snapshots are enabled. Separately, a short shift history keeps the most recent speed samples.

All banks share one combinational read port, selected by bank and counter index. The history has its own index port, and an index past the last entry returns zero.

Top module: `enc_capture_bank`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, the read bank, both snapshot banks, every history entry and `rd_pend` are zero.
- R2: The live bank (`bank_sel` = 0) shows, one clock edge later, the value on each counter input. Within every bank, `cnt_idx` selects 0 = revolution count, 1 = position, 2 = speed, 3 = timer. `bank_sel` selects 0 = live, 1 = read, 2 = snapshot 0, 3 = snapshot 1.
- R3: While `pause_in` is high, the live bank holds the counters whose `pause_mask` bit is set: bit 0 = revolution count, bit 1 = position, bit 2 = speed. The timer is never held. While `pause_in` is low, the mask has no effect.
- R4: A one-cycle pulse on `cmd_rd_wr` sets `rd_pend` at the next edge. At the following edge, all four live-bank values go into the read bank together and `rd_pend` clears, so it is high for exactly one cycle.
- R5: At any edge where some bit of `evt_flags` is set and the matching bit of `rd_en_mask` is also set, the read bank loads all four live-bank values. Events whose mask bit is clear leave the read bank unchanged.
- R6: With `snap_en` high, a rising edge of `snap_in[k]` loads snapshot bank k from the live bank at that edge. Holding the strobe high causes no further capture.
- R7: A rising strobe edge while `snap_en` is low does not change either snapshot bank.
- R8: During a cycle in which a bank is being loaded, reading that bank returns the value being captured, not the stored one.
- R9: Each `spd_push` pulse shifts the history. Entry 0 takes the current `live_spd` input, each other entry takes the previous contents of the entry below it, and the oldest entry is dropped. Without a push, the history is unchanged.
- R10: `hist_rdata` is zero for any `hist_idx` above 3, the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_z | input | CW | Live revolution counter |
| live_ph | input | CW | Live position counter |
| live_spd | input | CW | Live speed measurement |
| live_tmr | input | CW | Live timer |
| pause_in | input | 1 | Pause request |
| pause_mask | input | 3 | Counters held during pause |
| evt_flags | input | NUM_EVT | Event pulses |
| rd_en_mask | input | NUM_EVT | Events that load the read bank |
| cmd_rd_wr | input | 1 | Read command write pulse |
| snap_en | input | 1 | Snapshot enable |
| snap_in | input | 2 | Snapshot strobes |
| spd_push | input | 1 | New speed sample strobe |
| bank_sel | input | 2 | Bank select for reading |
| cnt_idx | input | 2 | Counter select for reading |
| bank_rdata | output | CW | Selected bank value |
| hist_idx | input | HIST_IDX_W | History entry select |
| hist_rdata | output | CW | Selected history entry, zero if out of range |
| rd_pend | output | 1 | Read command pending |

## Verification
The capture paths are tried with distinct value sets on all four counters, and the live inputs change right after each trigger. Because of this, a capture from the wrong cycle, or one that mixes counters, shows up as a mismatch. Events are applied both with and without their mask bit, and strobes are applied as a single rise, a held level and a rise while disabled; these separate edge detection from level sensing and from the enable gating. Reads are taken during the load cycle itself, which shows whether the bypass is present. The pause mask is changed while paused, to confirm each bit is mapped to the right counter and that the timer is left alone. History pushes use increasing values, so the shift order can be read back directly, and the out-of-range indices are probed as well.

// File: rtl/enc_cap_pkg.sv
package enc_cap_pkg;
   localparam int NUM_CNT  = 4;
   localparam int NUM_BANK = 4;

   typedef enum logic [1:0] {
      BANK_LIVE  = 2'd0,
      BANK_READ  = 2'd1,
      BANK_SNAP0 = 2'd2,
      BANK_SNAP1 = 2'd3
   } bank_sel_e;

   localparam int IDX_REV  = 0;
   localparam int IDX_POS  = 1;
   localparam int IDX_SPD  = 2;
   localparam int IDX_TMR  = 3;
endpackage

// File: rtl/ecb_live_stage.sv
module ecb_live_stage #(
   parameter int CW      = 32,
   parameter int NCNT    = 4,
   parameter int NPAUSE  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCNT-1:0][CW-1:0]   live,
   input  logic                      pause_in,
   input  logic [NPAUSE-1:0]         pause_mask,
   output logic [NCNT-1:0][CW-1:0]   cur_q
);
   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      if (i < NPAUSE) begin : g_pausable
         logic hold;
         assign hold = pause_in & pause_mask[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cur_q[i] <= '0;
            else if (!hold) cur_q[i] <= live[i];
         end
         // R3
         pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pause_in && pause_mask[i]) |=> $stable(cur_q[i]));
      end else begin : g_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur_q[i] <= '0;
            else        cur_q[i] <= live[i];
         end
      end
      // R2
      live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pause_in |=> cur_q[i] == $past(live[i]));
   end
endmodule

// File: rtl/ecb_trig_ctrl.sv
module ecb_trig_ctrl #(
   parameter int NUM_EVT  = 4,
   parameter int NUM_SNAP = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_rd_wr,
   input  logic [NUM_EVT-1:0]  evt_flags,
   input  logic [NUM_EVT-1:0]  rd_en_mask,
   input  logic                snap_en,
   input  logic [NUM_SNAP-1:0] snap_in,
   output logic                rd_pend_q,
   output logic                load_read,
   output logic [NUM_SNAP-1:0] load_snap
);
   logic [NUM_SNAP-1:0] snap_prev_q;
   logic                evt_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend_q   <= 1'b0;
         snap_prev_q <= '0;
      end else begin
         rd_pend_q   <= cmd_rd_wr;
         snap_prev_q <= snap_in;
      end
   end

   assign evt_hit   = |(evt_flags & rd_en_mask);
   assign load_read = rd_pend_q | evt_hit;
   assign load_snap = snap_en ? (snap_in & ~snap_prev_q) : '0;

   // R4
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pend_q && !cmd_rd_wr) |=> !rd_pend_q);
   // R6
   snap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_snap != '0) |=> ((load_snap & $past(load_snap)) == '0));
endmodule

// File: rtl/ecb_cap_bank.sv
module ecb_cap_bank #(
   parameter int CW   = 32,
   parameter int NCNT = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap_en,
   input  logic [NCNT-1:0][CW-1:0]   src,
   output logic [NCNT-1:0][CW-1:0]   view
);
   logic [NCNT-1:0][CW-1:0] bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bank_q <= '0;
      else if (cap_en) bank_q <= src;
   end

   assign view = cap_en ? src : bank_q;

   // R5 R7
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(bank_q));
   // R4
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> bank_q == $past(src));
endmodule

// File: rtl/ecb_spd_hist.sv
module ecb_spd_hist #(
   parameter int CW    = 32,
   parameter int DEPTH = 4,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [CW-1:0]    din,
   input  logic [IDX_W-1:0] idx,
   output logic [CW-1:0]    rdata
);
   localparam int SEL_W = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic [DEPTH-1:0][CW-1:0] hist_q;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      if (e == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hist_q[e] <= '0;
            else if (push) hist_q[e] <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hist_q[e] <= '0;
            else if (push) hist_q[e] <= hist_q[e-1];
         end
         // R9
         hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            push |=> hist_q[e] == $past(hist_q[e-1]));
      end
   end

   assign rdata = (idx <= LAST) ? hist_q[idx[SEL_W-1:0]] : '0;

   // R10
   hist_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx > LAST) |-> rdata == '0);
   // R9
   hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !push |=> $stable(hist_q));
endmodule

// File: rtl/enc_capture_bank.sv
module enc_capture_bank
   import enc_cap_pkg::*;
#(
   parameter int CW         = 32,
   parameter int NUM_EVT    = 4,
   parameter int HIST_DEPTH = 4,
   parameter int HIST_IDX_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CW-1:0]         live_z,
   input  logic [CW-1:0]         live_ph,
   input  logic [CW-1:0]         live_spd,
   input  logic [CW-1:0]         live_tmr,
   input  logic                  pause_in,
   input  logic [2:0]            pause_mask,
   input  logic [NUM_EVT-1:0]    evt_flags,
   input  logic [NUM_EVT-1:0]    rd_en_mask,
   input  logic                  cmd_rd_wr,
   input  logic                  snap_en,
   input  logic [1:0]            snap_in,
   input  logic                  spd_push,
   input  logic [1:0]            bank_sel,
   input  logic [1:0]            cnt_idx,
   output logic [CW-1:0]         bank_rdata,
   input  logic [HIST_IDX_W-1:0] hist_idx,
   output logic [CW-1:0]         hist_rdata,
   output logic                  rd_pend
);
   localparam int NUM_SNAP = 2;
   localparam int NUM_CAP  = NUM_BANK - 1;

   if (CW < 1) begin : g_bad_cw
      $error("CW must be at least 1");
   end
   if (NUM_EVT < 1) begin : g_bad_evt
      $error("NUM_EVT must be at least 1");
   end
   if (HIST_DEPTH < 2) begin : g_bad_depth
      $error("HIST_DEPTH must be at least 2");
   end
   if ((1 << HIST_IDX_W) <= HIST_DEPTH) begin : g_bad_idxw
      $error("HIST_IDX_W must reach past the last history entry");
   end

   logic [NUM_CNT-1:0][CW-1:0]               live_vec;
   logic [NUM_CNT-1:0][CW-1:0]               cur_q;
   logic [NUM_BANK-1:0][NUM_CNT-1:0][CW-1:0] views;
   logic [NUM_CAP-1:0]                        cap_en;
   logic                                      load_read;
   logic [NUM_SNAP-1:0]                       load_snap;

   assign live_vec[IDX_REV] = live_z;
   assign live_vec[IDX_POS] = live_ph;
   assign live_vec[IDX_SPD] = live_spd;
   assign live_vec[IDX_TMR] = live_tmr;

   ecb_live_stage #(.CW(CW), .NCNT(NUM_CNT), .NPAUSE(3)) u_live (
      .clk        (clk),
      .rst_n      (rst_n),
      .live       (live_vec),
      .pause_in   (pause_in),
      .pause_mask (pause_mask),
      .cur_q      (cur_q)
   );

   ecb_trig_ctrl #(.NUM_EVT(NUM_EVT), .NUM_SNAP(NUM_SNAP)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_rd_wr  (cmd_rd_wr),
      .evt_flags  (evt_flags),
      .rd_en_mask (rd_en_mask),
      .snap_en    (snap_en),
      .snap_in    (snap_in),
      .rd_pend_q  (rd_pend),
      .load_read  (load_read),
      .load_snap  (load_snap)
   );

   assign cap_en = {load_snap, load_read};
   assign views[BANK_LIVE] = cur_q;

   for (genvar b = 0; b < NUM_CAP; b++) begin : g_bank
      ecb_cap_bank #(.CW(CW), .NCNT(NUM_CNT)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .cap_en (cap_en[b]),
         .src    (cur_q),
         .view   (views[b+1])
      );
   end

   assign bank_rdata = views[bank_sel][cnt_idx];

   ecb_spd_hist #(.CW(CW), .DEPTH(HIST_DEPTH), .IDX_W(HIST_IDX_W)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (spd_push),
      .din   (live_spd),
      .idx   (hist_idx),
      .rdata (hist_rdata)
   );

   // R7
   snap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap_en && bank_sel == BANK_SNAP0) |=> $stable(views[BANK_SNAP0]) || bank_sel != BANK_SNAP0);
endmodule

// File: tb/enc_capture_bank_tb.sv
`timescale 1ns/1ps
module enc_capture_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] live_z = '0, live_ph = '0, live_spd = '0, live_tmr = '0;
   logic        pause_in = 1'b0;
   logic [2:0]  pause_mask = '0;
   logic [3:0]  evt_flags = '0, rd_en_mask = '0;
   logic        cmd_rd_wr = 1'b0, snap_en = 1'b0, spd_push = 1'b0;
   logic [1:0]  snap_in = '0, bank_sel = '0, cnt_idx = '0;
   logic [2:0]  hist_idx = '0;
   logic [31:0] bank_rdata, hist_rdata;
   logic        rd_pend;
   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   enc_capture_bank u_dut (
      .clk(clk), .rst_n(rst_n), .live_z(live_z), .live_ph(live_ph),
      .live_spd(live_spd), .live_tmr(live_tmr), .pause_in(pause_in),
      .pause_mask(pause_mask), .evt_flags(evt_flags), .rd_en_mask(rd_en_mask),
      .cmd_rd_wr(cmd_rd_wr), .snap_en(snap_en), .snap_in(snap_in),
      .spd_push(spd_push), .bank_sel(bank_sel), .cnt_idx(cnt_idx),
      .bank_rdata(bank_rdata), .hist_idx(hist_idx), .hist_rdata(hist_rdata),
      .rd_pend(rd_pend)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_live(input logic [31:0] a, b, c, d);
      live_z = a; live_ph = b; live_spd = c; live_tmr = d;
   endtask

   task automatic peek(input logic [1:0] sel, input logic [1:0] idx, output logic [31:0] v);
      bank_sel = sel; cnt_idx = idx; #1; v = bank_rdata;
   endtask

   task automatic chk_bank(input string req, input logic [1:0] sel,
                           input logic [31:0] a, b, c, d);
      logic [31:0] v;
      peek(sel, 2'd0, v); chk(req, v, a);
      peek(sel, 2'd1, v); chk(req, v, b);
      peek(sel, 2'd2, v); chk(req, v, c);
      peek(sel, 2'd3, v); chk(req, v, d);
   endtask

   task automatic t_reset();
      tick(); tick();
      chk("R1 pend in reset", {31'd0, rd_pend}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      set_live(32'h1, 32'h2, 32'h3, 32'h4);
      tick();
      chk("R1 pend", {31'd0, rd_pend}, 32'd0);
      chk_bank("R1 read bank", 2'd1, 0, 0, 0, 0);
      chk_bank("R1 snap0 bank", 2'd2, 0, 0, 0, 0);
      chk_bank("R1 snap1 bank", 2'd3, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) begin
         hist_idx = 3'(i); #1;
         chk("R1 history", hist_rdata, 32'd0);
      end
      chk_bank("R2 live order", 2'd0, 32'h1, 32'h2, 32'h3, 32'h4);
   endtask

   task automatic t_read_cmd();
      logic [31:0] v;
      set_live(32'h11, 32'h22, 32'h33, 32'h44);
      tick(); tick();
      cmd_rd_wr = 1'b1;
      tick();
      cmd_rd_wr = 1'b0;
      chk("R4 pend set", {31'd0, rd_pend}, 32'd1);
      peek(2'd1, 2'd2, v);
      chk("R8 read bypass", v, 32'h33);
      set_live(32'h99, 32'h98, 32'h97, 32'h96);
      tick();
      chk("R4 pend cleared", {31'd0, rd_pend}, 32'd0);
      chk_bank("R4 read bank coherent", 2'd1, 32'h11, 32'h22, 32'h33, 32'h44);
      chk_bank("R2 live follows", 2'd0, 32'h99, 32'h98, 32'h97, 32'h96);
      tick();
      chk("R4 pend stays low", {31'd0, rd_pend}, 32'd0);
   endtask

   task automatic t_event();
      logic [31:0] v;
      set_live(32'h5, 32'h6, 32'h7, 32'h8);
      tick(); tick();
      rd_en_mask = 4'b0010;
      evt_flags  = 4'b1000;
      tick();
      evt_flags  = 4'b0000;
      chk_bank("R5 unmasked event ignored", 2'd1, 32'h11, 32'h22, 32'h33, 32'h44);
      evt_flags = 4'b0010;
      peek(2'd1, 2'd0, v);
      chk("R8 event bypass", v, 32'h5);
      tick();
      evt_flags = 4'b0000;
      set_live(32'hA, 32'hB, 32'hC, 32'hD);
      tick();
      chk_bank("R5 masked event loads", 2'd1, 32'h5, 32'h6, 32'h7, 32'h8);
      rd_en_mask = 4'b0000;
   endtask

   task automatic t_snap();
      logic [31:0] v;
      snap_en = 1'b1;
      set_live(32'h100, 32'h101, 32'h102, 32'h103);
      tick(); tick();
      snap_in = 2'b01;
      peek(2'd2, 2'd3, v);
      chk("R8 snapshot bypass", v, 32'h103);
      tick();
      chk_bank("R6 snap0 captured", 2'd2, 32'h100, 32'h101, 32'h102, 32'h103);
      chk_bank("R6 snap1 untouched", 2'd3, 0, 0, 0, 0);
      set_live(32'h200, 32'h201, 32'h202, 32'h203);
      tick(); tick();
      chk_bank("R6 held level no recapture", 2'd2, 32'h100, 32'h101, 32'h102, 32'h103);
      snap_in = 2'b00;
      tick();
      snap_en = 1'b0;
      snap_in = 2'b10;
      tick();
      chk_bank("R7 disabled strobe ignored", 2'd3, 0, 0, 0, 0);
      snap_in = 2'b00;
      tick();
      snap_en = 1'b1;
      snap_in = 2'b10;
      tick();
      snap_in = 2'b00;
      chk_bank("R6 snap1 captured", 2'd3, 32'h200, 32'h201, 32'h202, 32'h203);
      chk_bank("R7 snap0 kept", 2'd2, 32'h100, 32'h101, 32'h102, 32'h103);
      snap_en = 1'b0;
   endtask

   task automatic t_pause();
      set_live(32'h1, 32'h2, 32'h3, 32'h4);
      tick(); tick();
      pause_mask = 3'b001;
      pause_in   = 1'b1;
      set_live(32'h9, 32'h9, 32'h9, 32'h9);
      tick();
      chk_bank("R3 hold revolution only", 2'd0, 32'h1, 32'h9, 32'h9, 32'h9);
      pause_mask = 3'b110;
      set_live(32'h7, 32'h7, 32'h7, 32'h7);
      tick();
      chk_bank("R3 hold position and speed", 2'd0, 32'h7, 32'h9, 32'h9, 32'h7);
      pause_mask = 3'b111;
      set_live(32'h5, 32'h5, 32'h5, 32'h5);
      tick();
      chk_bank("R3 timer never held", 2'd0, 32'h7, 32'h9, 32'h9, 32'h5);
      pause_in = 1'b0;
      tick();
      chk_bank("R3 mask inert without pause", 2'd0, 32'h5, 32'h5, 32'h5, 32'h5);
      pause_mask = 3'b000;
   endtask

   task automatic t_hist();
      for (int k = 1; k <= 5; k++) begin
         live_spd = 32'(k * 16);
         spd_push = 1'b1;
         tick();
         spd_push = 1'b0;
      end
      live_spd = 32'hFFFF;
      tick(); tick();
      for (int i = 0; i < 4; i++) begin
         hist_idx = 3'(i); #1;
         chk("R9 history order", hist_rdata, 32'((5 - i) * 16));
      end
      for (int i = 4; i < 8; i++) begin
         hist_idx = 3'(i); #1;
         chk("R10 out of range zero", hist_rdata, 32'd0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_read_cmd();
      t_event();
      t_snap();
      t_pause();
      t_hist();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule